// File: doc/BRIEF.md
# Software-Managed Set-Associative TLB

This block holds address translations in a set-associative array that software fills and maintains itself. Software reaches it through four registers selected by a two-bit address: a virtual-side descriptor, a physical-side descriptor, an entry index and a command register. Each write to the command register runs one operation in a single clock. The operations are:

- search the array for the virtual-side descriptor
- choose a slot for a new entry
- store an entry, with or without a flush strobe to a small downstream translation cache
- copy an entry back into the descriptor registers
- send a bare flush strobe

A separate lookup port translates a virtual page and address-space ID in the same cycle. It reports a unique hit, a miss or a multiple match, and it returns the physical-side word of the hit entry.

Entries are numbered linearly, with the ways of one set next to each other. Duplicate entries are accepted when they are written. They are flagged only when a search or lookup matches more than one way.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid, the three descriptor and index registers read zero, and `uTlbInval` is low.
- R2: `regSel` picks the register: 0 is the virtual descriptor (VD), 1 is the physical descriptor (PD), 2 is INDEX and 3 is COMMAND. A write with `regWrEn` loads VD, PD or INDEX, and `regRdData` shows the selected register, with COMMAND reading as zero. Bits [3:0] of a COMMAND write give the operation code.
- R3: The VD layout is: virtual page in bits [31:PAGE_BITS], global flag in bit 9, present flag in bit 8, ID in bits [7:0]. The set is virtual-page bits [SET_W-1:0], and the linear index is set × NUM_WAYS + way.
- R4: An entry matches when its present flag is set, its virtual page is equal, and either its ID is equal or its global flag is set.
- R5: Code 1 (search) checks the set named by VD against VD's page and ID. One match loads INDEX with that entry's linear index. No match loads 0x8000_0000. More than one match loads 0xC000_0000.
- R6: Code 2 (allocate) loads INDEX with the linear index of the lowest-numbered invalid way in VD's set. If every way of the set is valid, it uses the way given by a rotating pointer. That pointer starts at 0 and advances by one, modulo NUM_WAYS, on every allocate.
- R7: Code 3 stores VD and PD into the entry at INDEX[IDX_W-1:0], even when that creates a duplicate. `uTlbInval` is high for exactly the one cycle that follows.
- R8: Code 4 stores the entry as code 3 does, but leaves `uTlbInval` low.
- R9: Code 5 loads VD and PD from the entry at INDEX[IDX_W-1:0].
- R10: Code 6 raises `uTlbInval` for one cycle and changes no entry and no register.
- R11: The lookup port works combinationally. `lkHit` means exactly one match, `lkMiss` means none and `lkMulti` means more than one. `lkPd1` is the PD of the lowest matching way, or zero when nothing matches.
- R12: Codes 0 and 7 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Selected register contents |
| lkVpn | input | 32-PAGE_BITS | Lookup virtual page |
| lkAsid | input | 8 | Lookup address-space ID |
| lkHit | output | 1 | Exactly one way matches |
| lkMiss | output | 1 | No way matches |
| lkMulti | output | 1 | Several ways match |
| lkPd1 | output | 32 | Physical descriptor of the hit |
| uTlbInval | output | 1 | Flush strobe for the downstream cache |

## Verification
The hardest state to reach is a set holding two valid entries that match the same page, because allocation never produces one. The stimulus builds it on purpose. It loads INDEX by hand with two ways of one set and stores the same descriptor twice with the non-flushing store. It then runs a search and a lookup. The rotating allocation pointer is also only visible once a set is full, so the bench fills a set through allocation first and then allocates again.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_PROBE    = 4'd1,
    CMD_GETIDX   = 4'd2,
    CMD_WRITE    = 4'd3,
    CMD_WRITE_NI = 4'd4,
    CMD_READ     = 4'd5,
    CMD_UINVAL   = 4'd6
  } tlbCmdE;

  typedef enum logic [1:0] {
    SEL_VD  = 2'd0,
    SEL_PD  = 2'd1,
    SEL_IDX = 2'd2,
    SEL_CMD = 2'd3
  } regSelE;

  typedef struct packed {
    logic ldVd;
    logic ldPd;
    logic ldIdx;
    logic doProbe;
    logic doGetIdx;
    logic doWrite;
    logic doRead;
  } tlbStrobeT;

  localparam int ASID_W     = 8;
  localparam int VALID_BIT  = 8;
  localparam int GLOBAL_BIT = 9;
  localparam logic [31:0] IDX_NOTFOUND = 32'h8000_0000;
  localparam logic [31:0] IDX_DUP      = 32'hC000_0000;

endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [3:0] cmdCode,
  output tlbStrobeT  strobe,
  output logic       uTlbInval
);

  logic cmdWr;
  logic pulseNext;

  assign cmdWr = regWrEn && (regSel == SEL_CMD);

  always_comb begin
    strobe          = '0;
    strobe.ldVd     = regWrEn && (regSel == SEL_VD);
    strobe.ldPd     = regWrEn && (regSel == SEL_PD);
    strobe.ldIdx    = regWrEn && (regSel == SEL_IDX);
    strobe.doProbe  = cmdWr && (cmdCode == CMD_PROBE);
    strobe.doGetIdx = cmdWr && (cmdCode == CMD_GETIDX);
    strobe.doWrite  = cmdWr && ((cmdCode == CMD_WRITE) || (cmdCode == CMD_WRITE_NI));
    strobe.doRead   = cmdWr && (cmdCode == CMD_READ);
  end

  assign pulseNext = cmdWr && ((cmdCode == CMD_WRITE) || (cmdCode == CMD_UINVAL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uTlbInval <= 1'b0;
    else       uTlbInval <= pulseNext;
  end

  // R8: a non-flushing store never produces the strobe
  p_ni_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_CMD && cmdCode == CMD_WRITE_NI) |=> !uTlbInval);

  // R10: the strobe lasts a single cycle unless re-requested
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (uTlbInval && !$past(cmdWr)) |-> 1'b0 || !uTlbInval || $past(pulseNext));

endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int NUM_SETS  = 128,
  parameter int NUM_WAYS  = 2,
  parameter int PAGE_BITS = 13,
  localparam int VPN_W    = 32 - PAGE_BITS,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int IDX_W    = SET_W + WAY_W,
  localparam int NUM_ENT  = NUM_SETS * NUM_WAYS
)(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobeT         strobe,
  input  logic [31:0]       wrData,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic [31:0]       vdQ,
  output logic [31:0]       pdQ,
  output logic [31:0]       indexQ,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkMulti,
  output logic [31:0]       lkPd1
);

  logic [31:0] eVd [NUM_ENT];
  logic [31:0] ePd [NUM_ENT];
  logic [WAY_W-1:0] rrPtr;

  logic [SET_W-1:0] probeSet, lkSet;
  logic [NUM_WAYS-1:0] probeHitV, lkHitV, freeV;
  logic [WAY_W-1:0] probeWay, lkWay, freeWay, allocWay;
  int probeCnt, lkCnt;
  logic [IDX_W-1:0] selIdx;

  function automatic logic entryMatch(input logic [31:0] e,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASID_W-1:0] asid);
    return e[VALID_BIT] && (e[31:PAGE_BITS] == vpn) &&
           (e[GLOBAL_BIT] || (e[ASID_W-1:0] == asid));
  endfunction

  assign probeSet = vdQ[PAGE_BITS +: SET_W];
  assign lkSet    = lkVpn[SET_W-1:0];
  assign selIdx   = indexQ[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign probeHitV[w] = entryMatch(eVd[{probeSet, WI}], vdQ[31:PAGE_BITS], vdQ[ASID_W-1:0]);
    assign lkHitV[w]    = entryMatch(eVd[{lkSet, WI}], lkVpn, lkAsid);
    assign freeV[w]     = !eVd[{probeSet, WI}][VALID_BIT];
  end

  always_comb begin
    probeWay = '0;
    lkWay    = '0;
    freeWay  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (probeHitV[w]) probeWay = WAY_W'(w);
      if (lkHitV[w])    lkWay    = WAY_W'(w);
      if (freeV[w])     freeWay  = WAY_W'(w);
    end
  end

  assign probeCnt = int'($countones(probeHitV));
  assign lkCnt    = int'($countones(lkHitV));
  assign allocWay = (|freeV) ? freeWay : rrPtr;

  assign lkHit   = (lkCnt == 1);
  assign lkMiss  = (lkCnt == 0);
  assign lkMulti = (lkCnt > 1);
  assign lkPd1   = (|lkHitV) ? ePd[{lkSet, lkWay}] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vdQ    <= '0;
      pdQ    <= '0;
      indexQ <= '0;
      rrPtr  <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        eVd[i] <= '0;
        ePd[i] <= '0;
      end
    end else begin
      if (strobe.ldVd)  vdQ    <= wrData;
      if (strobe.ldPd)  pdQ    <= wrData;
      if (strobe.ldIdx) indexQ <= wrData;
      if (strobe.doProbe) begin
        if (probeCnt == 0)      indexQ <= IDX_NOTFOUND;
        else if (probeCnt == 1) indexQ <= 32'({probeSet, probeWay});
        else                    indexQ <= IDX_DUP;
      end
      if (strobe.doGetIdx) begin
        indexQ <= 32'({probeSet, allocWay});
        rrPtr  <= rrPtr + 1'b1;
      end
      if (strobe.doWrite) begin
        eVd[selIdx] <= vdQ;
        ePd[selIdx] <= pdQ;
      end
      if (strobe.doRead) begin
        vdQ <= eVd[selIdx];
        pdQ <= ePd[selIdx];
      end
    end
  end

  // R5: a search result is an error code or an index inside the searched set
  p_probe_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doProbe |=> (indexQ == IDX_NOTFOUND) || (indexQ == IDX_DUP) ||
                       ((indexQ[31:IDX_W] == '0) && (indexQ[IDX_W-1:WAY_W] == $past(probeSet))));

  // R6: allocation always lands in the set named by VD
  p_alloc_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doGetIdx |=> (indexQ[31:IDX_W] == '0) && (indexQ[IDX_W-1:WAY_W] == $past(probeSet)));

  // R7: a store leaves the descriptors in the indexed entry
  p_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> (eVd[$past(selIdx)] == $past(vdQ)) && (ePd[$past(selIdx)] == $past(pdQ)));

  // R11: lookup outcomes are mutually exclusive
  p_lk_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({lkHit, lkMiss, lkMulti}) == 1);

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int NUM_SETS  = 128,
  parameter int NUM_WAYS  = 2,
  parameter int PAGE_BITS = 13
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [31-PAGE_BITS:0]  lkVpn,
  input  logic [7:0]             lkAsid,
  output logic                   lkHit,
  output logic                   lkMiss,
  output logic                   lkMulti,
  output logic [31:0]            lkPd1,
  output logic                   uTlbInval
);

  tlbStrobeT strobe;
  logic [31:0] vdQ, pdQ, indexQ;

  soft_tlb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .cmdCode(regWrData[3:0]), .strobe(strobe), .uTlbInval(uTlbInval)
  );

  soft_tlb_dp #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .PAGE_BITS(PAGE_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .vdQ(vdQ), .pdQ(pdQ), .indexQ(indexQ),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkMulti(lkMulti), .lkPd1(lkPd1)
  );

  always_comb begin
    case (regSel)
      SEL_VD:  regRdData = vdQ;
      SEL_PD:  regRdData = pdQ;
      SEL_IDX: regRdData = indexQ;
      default: regRdData = '0;
    endcase
  end

endmodule

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;
  localparam int NS = 128, NW = 2, PB = 13, NE = NS * NW;
  localparam logic [31:0] NF = 32'h8000_0000, DUP = 32'hC000_0000;

  logic clk = 0, rstN = 0, regWrEn = 0;
  logic [1:0] regSel = 0;
  logic [31:0] regWrData = 0, regRdData, lkPd1;
  logic [31-PB:0] lkVpn = 0;
  logic [7:0] lkAsid = 0;
  logic lkHit, lkMiss, lkMulti, uTlbInval;

  always #2 clk = ~clk;

  soft_tlb i_soft_tlb (.*);

  int total = 0, bad = 0;
  bit running = 0, done = 0;
  logic [31:0] mVd [NE];
  logic [31:0] mPd [NE];
  logic [31:0] mR0 = 0, mR1 = 0, mIdx = 0;
  int mRr = 0;
  logic nextInval = 0, expInval = 0, lastInval;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mMatch(logic [31:0] e, logic [31:0] vpn, logic [7:0] a);
    return e[8] && ((e >> PB) == vpn) && (e[9] || e[7:0] == a);
  endfunction

  task automatic mSearch(input logic [31:0] vpn, input logic [7:0] a,
                         output int cnt, output int first);
    int s = vpn % NS;
    cnt = 0; first = -1;
    for (int w = 0; w < NW; w++)
      if (mMatch(mVd[s*NW+w], vpn, a)) begin
        cnt++;
        if (first < 0) first = s*NW+w;
      end
  endtask

  always @(posedge clk) expInval <= nextInval;

  always @(negedge clk) begin
    #1;
    if (rstN && running) begin
      int c, f;
      logic [31:0] expRd;
      mSearch(32'(lkVpn), lkAsid, c, f);
      chk("R11 outcome", {29'd0, lkHit, lkMiss, lkMulti}, {29'd0, c == 1, c == 0, c > 1});
      chk("R11 pd", lkPd1, (f < 0) ? 32'd0 : mPd[f]);
      expRd = (regSel == 0) ? mR0 : (regSel == 1) ? mR1 : (regSel == 2) ? mIdx : 32'd0;
      chk("R2 readback", regRdData, expRd);
      chk("R7 R10 strobe", {31'd0, uTlbInval}, {31'd0, expInval});
    end
  end

  task automatic op(input int sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1; regSel = 2'(sel); regWrData = data;
    nextInval = (sel == 3) && (data[3:0] == 3 || data[3:0] == 6);
    @(posedge clk); #1;
    nextInval = 0;
    case (sel)
      0: mR0 = data;
      1: mR1 = data;
      2: mIdx = data;
      default: begin
        int s = (mR0 >> PB) % NS;
        int i = mIdx % NE;
        case (data[3:0])
          4'd1: begin
            int c, f;
            mSearch(mR0 >> PB, mR0[7:0], c, f);
            mIdx = (c == 0) ? NF : (c == 1) ? 32'(f) : DUP;
          end
          4'd2: begin
            int fw = -1;
            for (int w = NW - 1; w >= 0; w--) if (!mVd[s*NW+w][8]) fw = w;
            mIdx = 32'(s*NW + ((fw >= 0) ? fw : mRr));
            mRr = (mRr + 1) % NW;
          end
          4'd3, 4'd4: begin mVd[i] = mR0; mPd[i] = mR1; end
          4'd5: begin mR0 = mVd[i]; mR1 = mPd[i]; end
          default: ;
        endcase
      end
    endcase
    @(negedge clk);
    regWrEn = 0;
    #1 lastInval = uTlbInval;
  endtask

  task automatic peek(input int sel, output logic [31:0] v);
    @(negedge clk);
    regSel = 2'(sel);
    #1 v = regRdData;
  endtask

  task automatic look(input logic [31:0] vpn, input logic [7:0] a);
    @(negedge clk);
    lkVpn = (32-PB)'(vpn); lkAsid = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NE; i++) begin mVd[i] = 0; mPd[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    running = 1;

    // R1 reset state
    peek(0, v); chk("R1 vd", v, 0);
    peek(1, v); chk("R1 pd", v, 0);
    peek(2, v); chk("R1 index", v, 0);
    chk("R1 strobe", {31'd0, uTlbInval}, 0);
    look(5, 3); chk("R1 miss", {31'd0, lkMiss}, 1);

    // R3 R6 allocation into set 5
    op(0, 32'h0000_A103); op(1, 32'h0040_0015);
    op(3, 2); peek(2, v); chk("R3 R6 first free", v, 10);
    op(3, 3); chk("R7 strobe", {31'd0, lastInval}, 1);
    op(3, 2); peek(2, v); chk("R6 second free", v, 11);
    op(0, 32'h0010_A103); op(1, 32'h0080_0027); op(3, 3);
    op(0, 32'h0000_A103);
    op(3, 2); peek(2, v); chk("R6 rotate way0", v, 10);
    op(3, 2); peek(2, v); chk("R6 rotate way1", v, 11);

    // R4 match rules
    look(5, 3); chk("R4 hit", {31'd0, lkHit}, 1); chk("R11 pd", lkPd1, 32'h0040_0015);
    look(5, 4); chk("R4 id mismatch", {31'd0, lkMiss}, 1);
    op(0, 32'h0000_C307); op(1, 32'h0123_0038); op(2, 12); op(3, 3);
    look(6, 8'h55); chk("R4 global", {31'd0, lkHit}, 1);
    op(0, 32'h0000_E003); op(2, 14); op(3, 3);
    look(7, 3); chk("R4 not present", {31'd0, lkMiss}, 1);

    // R5 search
    op(0, 32'h0000_A103); op(3, 1); peek(2, v); chk("R5 single", v, 10);
    op(0, 32'h0000_E103); op(3, 1); peek(2, v); chk("R5 none", v, NF);

    // R8 duplicate via non-flushing store
    op(0, 32'h0000_C307); op(2, 13); op(3, 4);
    chk("R8 no strobe", {31'd0, lastInval}, 0);
    op(3, 1); peek(2, v); chk("R5 dup", v, DUP);
    look(6, 8'h12); chk("R11 multi", {31'd0, lkMulti}, 1);

    // R9 read back
    op(2, 11); op(3, 5);
    peek(0, v); chk("R9 vd", v, 32'h0010_A103);
    peek(1, v); chk("R9 pd", v, 32'h0080_0027);

    // R10 bare flush
    op(3, 6); chk("R10 strobe", {31'd0, lastInval}, 1);
    peek(0, v); chk("R10 vd kept", v, 32'h0010_A103);

    // R12 unused codes
    op(3, 9); chk("R12 no strobe", {31'd0, lastInval}, 0);
    peek(2, v); chk("R12 index kept", v, 11);
    op(3, 0); look(0, 0); look(5, 3); chk("R12 entry kept", {31'd0, lkHit}, 1);

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule